// File: doc/BRIEF.md
# DMA Channel Descriptor Sequencer

This block is the control engine of a single DMA channel. It keeps the channel in one of three states: disabled, enabled or paused. It holds the current source and destination descriptor pointers, each 49 bits wide. It asks an external fetch path for descriptors and for link words, and it decides what follows each completed descriptor. The data movement itself is done elsewhere. The sequencer starts it with `xfer_go` and learns that it has finished from `xfer_cmpl`.

Descriptors are 16 bytes long. Successive descriptors are found in one of two ways. A linear descriptor is followed by the one placed directly after it. A linked descriptor is followed by the one whose address is held in the word stored 16 bytes past its own start. The command field of a descriptor can end the run (stop) or suspend it (halt). A suspended channel continues either at its next descriptor or from the programmed start addresses. In register mode the descriptors come from registers rather than memory, so the channel runs exactly one descriptor and then disables itself.

Software control arrives as a write strobe that loads the enable, continue and continue-from-start bits together.

Top module: `dma_chan_seq`

## Requirements
- R1: `status` reads 0 when disabled, 1 when enabled (any active phase) and 2 when paused. It reads 3 whenever an error is latched, and this overrides the state.
- R2: A write with enable set, while the channel is disabled, copies `dst_start` and `src_start` into the current pointers. The channel then becomes enabled and issues a destination descriptor request (`mem_kind`=0) at the destination pointer, followed by a source descriptor request (`mem_kind`=1) at the source pointer.
- R3: In memory mode (`reg_mode`=0), a descriptor address whose low 4 bits are not zero issues no request. Instead it latches the error, pulses `dst_rd_err` or `src_rd_err` for the side at fault, clears `en_o` and disables the channel. In register mode no alignment check is made.
- R4: After a descriptor with command 0, a linear descriptor (`dsc_linked`=0) advances the source pointer by 16. A linked descriptor first issues a link request (`mem_kind`=2) at pointer+16, and the returned `mem_rdata` becomes the source pointer.
- R5: Command 2 (stop), or any completion in register mode, clears `en_o` and moves the channel to disabled.
- R6: Command 1 (halt) moves the channel to paused and pulses `pause_evt`.
- R7: While paused with both continue and enable set, the channel resumes. With continue-from-start set it reloads both pointers from the start inputs and fetches the destination descriptor first. Otherwise it advances the source pointer according to the halted descriptor's type. `cont_o` clears as the channel resumes.
- R8: While paused, continue set with enable clear moves the channel to disabled without issuing any request.
- R9: Any write with enable set clears a latched error.
- R10: Every descriptor completion pulses `done_evt`. `src_done_evt` pulses together with it only when the descriptor's interrupt flag (`dsc_irq`) was set.
- R11: `mem_req` is a one-cycle pulse. No new request is issued until `mem_valid` has answered the previous one.
- R12: After a source descriptor arrives, `xfer_go` pulses once, with `xfer_size` equal to that descriptor's size field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Strobe that loads the three control bits |
| cfg_en | input | 1 | Enable bit value |
| cfg_cont | input | 1 | Continue bit value |
| cfg_from_start | input | 1 | Continue-from-start bit value |
| reg_mode | input | 1 | 1: descriptors held in registers (single descriptor run) |
| src_start | input | ADDR_W | Source descriptor start address |
| dst_start | input | ADDR_W | Destination descriptor start address |
| mem_req | output | 1 | Fetch request pulse |
| mem_kind | output | 2 | 0 destination descriptor, 1 source descriptor, 2 link word |
| mem_addr | output | ADDR_W | Fetch address |
| mem_valid | input | 1 | Fetch response strobe |
| mem_rdata | input | ADDR_W | Pointer bits of the returned link word |
| dsc_size | input | SIZE_W | Source descriptor size field |
| dsc_linked | input | 1 | Source descriptor type: 1 linked, 0 linear |
| dsc_cmd | input | 2 | Source descriptor command: 1 halt, 2 stop |
| dsc_irq | input | 1 | Source descriptor interrupt flag |
| xfer_go | output | 1 | Start pulse to the data mover |
| xfer_size | output | SIZE_W | Byte count for the data mover |
| xfer_cmpl | input | 1 | Data mover completion pulse |
| en_o | output | 1 | Current enable bit |
| cont_o | output | 1 | Current continue bit |
| status | output | 2 | Channel status code |
| done_evt | output | 1 | Descriptor completion event |
| src_done_evt | output | 1 | Source descriptor interrupt event |
| pause_evt | output | 1 | Pause event |
| src_rd_err | output | 1 | Source descriptor address error pulse |
| dst_rd_err | output | 1 | Destination descriptor address error pulse |
| src_ptr_o | output | ADDR_W | Current source descriptor pointer |
| dst_ptr_o | output | ADDR_W | Current destination descriptor pointer |

## Verification
The assertions assume a well-behaved environment:
- `mem_valid` answers each request exactly once and no sooner than the cycle after `mem_req`.
- `xfer_cmpl` arrives only after `xfer_go`.
- `reg_mode` and the start addresses stay still while the channel is active.
- No control write lands in the cycle in which the sequencer itself clears enable.

The bench meets these conditions with two responder processes, each of which reacts to one pulse at a time after a random delay of one to three cycles. The bench changes the mode and the start addresses only while `status` is 0 or 3, and issues control writes only when the channel is disabled or paused.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [3:0] {
    ST_OFF, ST_DST_REQ, ST_DST_WAIT, ST_SRC_REQ, ST_SRC_WAIT,
    ST_RUN, ST_LNK_REQ, ST_LNK_WAIT, ST_PAUSE
  } dcs_state_e;

  localparam logic [1:0] KIND_DST  = 2'd0;
  localparam logic [1:0] KIND_SRC  = 2'd1;
  localparam logic [1:0] KIND_NEXT = 2'd2;

  localparam logic [1:0] CMD_HALT = 2'd1;
  localparam logic [1:0] CMD_STOP = 2'd2;

  localparam logic [1:0] STAT_OFF   = 2'd0;
  localparam logic [1:0] STAT_RUN   = 2'd1;
  localparam logic [1:0] STAT_PAUSE = 2'd2;
  localparam logic [1:0] STAT_ERR   = 2'd3;
endpackage

// File: rtl/dcs_ptr.sv
// Current descriptor pointers: index 0 destination, index 1 source.
module dcs_ptr #(
  parameter int ADDR_W    = 49,
  parameter int DSC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_start,
  input  logic              step_lin,
  input  logic              load_next,
  input  logic [ADDR_W-1:0] src_start,
  input  logic [ADDR_W-1:0] dst_start,
  input  logic [ADDR_W-1:0] next_ptr,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output logic [ADDR_W-1:0] link_addr,
  output logic [1:0]        misalign
);
  localparam int ALIGN_W = $clog2(DSC_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DSC_BYTES);

  logic [ADDR_W-1:0] ptr_q [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q[0] <= '0;
      ptr_q[1] <= '0;
    end else if (load_start) begin
      ptr_q[0] <= dst_start;
      ptr_q[1] <= src_start;
    end else if (step_lin) begin
      ptr_q[1] <= ptr_q[1] + STEP;
    end else if (load_next) begin
      ptr_q[1] <= next_ptr;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_align
    assign misalign[g] = |ptr_q[g][ALIGN_W-1:0];
  end

  assign dst_ptr   = ptr_q[0];
  assign src_ptr   = ptr_q[1];
  assign link_addr = ptr_q[1] + STEP;
endmodule

// File: rtl/dcs_fsm.sv
module dcs_fsm
  import dcs_pkg::*;
#(
  parameter int ADDR_W = 49,
  parameter int SIZE_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic              cfg_cont,
  input  logic              cfg_from_start,
  input  logic              reg_mode,
  input  logic [1:0]        misalign,
  input  logic [ADDR_W-1:0] src_ptr,
  input  logic [ADDR_W-1:0] dst_ptr,
  input  logic [ADDR_W-1:0] link_addr,
  input  logic              mem_valid,
  input  logic [SIZE_W-1:0] dsc_size,
  input  logic              dsc_linked,
  input  logic [1:0]        dsc_cmd,
  input  logic              dsc_irq,
  input  logic              xfer_cmpl,
  output logic              load_start,
  output logic              step_lin,
  output logic              load_next,
  output logic              mem_req,
  output logic [1:0]        mem_kind,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              xfer_go,
  output logic [SIZE_W-1:0] xfer_size,
  output logic              en_o,
  output logic              cont_o,
  output logic [1:0]        status,
  output logic              done_evt,
  output logic              src_done_evt,
  output logic              pause_evt,
  output logic              src_rd_err,
  output logic              dst_rd_err
);
  dcs_state_e st_q, st_d;
  logic en_q, cont_q, fs_q, err_q;
  logic linked_q, irq_q;
  logic [1:0] cmd_q;

  logic issue, go, cmpl, stop, halt, leave_pause, bad_src, bad_dst;
  logic [1:0]        issue_kind;
  logic [ADDR_W-1:0] issue_addr;

  always_comb begin
    st_d        = st_q;
    load_start  = 1'b0;
    step_lin    = 1'b0;
    load_next   = 1'b0;
    issue       = 1'b0;
    issue_kind  = KIND_DST;
    issue_addr  = dst_ptr;
    go          = 1'b0;
    cmpl        = 1'b0;
    stop        = 1'b0;
    halt        = 1'b0;
    leave_pause = 1'b0;
    bad_src     = 1'b0;
    bad_dst     = 1'b0;
    case (st_q)
      ST_OFF: begin
        if (en_q) begin
          load_start = 1'b1;
          st_d       = ST_DST_REQ;
        end
      end
      ST_DST_REQ: begin
        if (!reg_mode && misalign[0]) begin
          bad_dst = 1'b1;
          st_d    = ST_OFF;
        end else begin
          issue = 1'b1;
          st_d  = ST_DST_WAIT;
        end
      end
      ST_DST_WAIT: if (mem_valid) st_d = ST_SRC_REQ;
      ST_SRC_REQ: begin
        if (!reg_mode && misalign[1]) begin
          bad_src = 1'b1;
          st_d    = ST_OFF;
        end else begin
          issue      = 1'b1;
          issue_kind = KIND_SRC;
          issue_addr = src_ptr;
          st_d       = ST_SRC_WAIT;
        end
      end
      ST_SRC_WAIT: begin
        if (mem_valid) begin
          go   = 1'b1;
          st_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (xfer_cmpl) begin
          cmpl = 1'b1;
          if (reg_mode || cmd_q == CMD_STOP) begin
            stop = 1'b1;
            st_d = ST_OFF;
          end else if (cmd_q == CMD_HALT) begin
            halt = 1'b1;
            st_d = ST_PAUSE;
          end else if (linked_q) begin
            st_d = ST_LNK_REQ;
          end else begin
            step_lin = 1'b1;
            st_d     = ST_SRC_REQ;
          end
        end
      end
      ST_LNK_REQ: begin
        issue      = 1'b1;
        issue_kind = KIND_NEXT;
        issue_addr = link_addr;
        st_d       = ST_LNK_WAIT;
      end
      ST_LNK_WAIT: begin
        if (mem_valid) begin
          load_next = 1'b1;
          st_d      = ST_SRC_REQ;
        end
      end
      ST_PAUSE: begin
        if (cont_q) begin
          leave_pause = 1'b1;
          if (!en_q) begin
            st_d = ST_OFF;
          end else if (fs_q) begin
            load_start = 1'b1;
            st_d       = ST_DST_REQ;
          end else if (linked_q) begin
            st_d = ST_LNK_REQ;
          end else begin
            step_lin = 1'b1;
            st_d     = ST_SRC_REQ;
          end
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_OFF;
      en_q         <= 1'b0;
      cont_q       <= 1'b0;
      fs_q         <= 1'b0;
      err_q        <= 1'b0;
      linked_q     <= 1'b0;
      irq_q        <= 1'b0;
      cmd_q        <= '0;
      mem_req      <= 1'b0;
      mem_kind     <= KIND_DST;
      mem_addr     <= '0;
      xfer_go      <= 1'b0;
      xfer_size    <= '0;
      done_evt     <= 1'b0;
      src_done_evt <= 1'b0;
      pause_evt    <= 1'b0;
      src_rd_err   <= 1'b0;
      dst_rd_err   <= 1'b0;
    end else begin
      st_q         <= st_d;
      mem_req      <= issue;
      xfer_go      <= go;
      done_evt     <= cmpl;
      src_done_evt <= cmpl && irq_q;
      pause_evt    <= halt;
      src_rd_err   <= bad_src;
      dst_rd_err   <= bad_dst;
      if (issue) begin
        mem_kind <= issue_kind;
        mem_addr <= issue_addr;
      end
      if (go) begin
        xfer_size <= dsc_size;
        linked_q  <= dsc_linked;
        cmd_q     <= dsc_cmd;
        irq_q     <= dsc_irq;
      end
      if (cfg_wr) begin
        en_q   <= cfg_en;
        cont_q <= cfg_cont;
        fs_q   <= cfg_from_start;
        if (cfg_en) err_q <= 1'b0;
      end
      if (stop || bad_src || bad_dst) en_q <= 1'b0;
      if (bad_src || bad_dst) err_q <= 1'b1;
      if (leave_pause) cont_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign cont_o = cont_q;
  assign status = err_q             ? STAT_ERR   :
                  (st_q == ST_OFF)   ? STAT_OFF   :
                  (st_q == ST_PAUSE) ? STAT_PAUSE : STAT_RUN;
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int ADDR_W    = 49,
  parameter int SIZE_W    = 30,
  parameter int DSC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic              cfg_cont,
  input  logic              cfg_from_start,
  input  logic              reg_mode,
  input  logic [ADDR_W-1:0] src_start,
  input  logic [ADDR_W-1:0] dst_start,
  output logic              mem_req,
  output logic [1:0]        mem_kind,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic [SIZE_W-1:0] dsc_size,
  input  logic              dsc_linked,
  input  logic [1:0]        dsc_cmd,
  input  logic              dsc_irq,
  output logic              xfer_go,
  output logic [SIZE_W-1:0] xfer_size,
  input  logic              xfer_cmpl,
  output logic              en_o,
  output logic              cont_o,
  output logic [1:0]        status,
  output logic              done_evt,
  output logic              src_done_evt,
  output logic              pause_evt,
  output logic              src_rd_err,
  output logic              dst_rd_err,
  output logic [ADDR_W-1:0] src_ptr_o,
  output logic [ADDR_W-1:0] dst_ptr_o
);
  localparam int ALIGN_W = $clog2(DSC_BYTES);

  logic              load_start, step_lin, load_next;
  logic [ADDR_W-1:0] link_addr;
  logic [1:0]        misalign;

  dcs_ptr #(.ADDR_W(ADDR_W), .DSC_BYTES(DSC_BYTES)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .load_start (load_start),
    .step_lin   (step_lin),
    .load_next  (load_next),
    .src_start  (src_start),
    .dst_start  (dst_start),
    .next_ptr   (mem_rdata),
    .src_ptr    (src_ptr_o),
    .dst_ptr    (dst_ptr_o),
    .link_addr  (link_addr),
    .misalign   (misalign)
  );

  dcs_fsm #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .cfg_wr         (cfg_wr),
    .cfg_en         (cfg_en),
    .cfg_cont       (cfg_cont),
    .cfg_from_start (cfg_from_start),
    .reg_mode       (reg_mode),
    .misalign       (misalign),
    .src_ptr        (src_ptr_o),
    .dst_ptr        (dst_ptr_o),
    .link_addr      (link_addr),
    .mem_valid      (mem_valid),
    .dsc_size       (dsc_size),
    .dsc_linked     (dsc_linked),
    .dsc_cmd        (dsc_cmd),
    .dsc_irq        (dsc_irq),
    .xfer_cmpl      (xfer_cmpl),
    .load_start     (load_start),
    .step_lin       (step_lin),
    .load_next      (load_next),
    .mem_req        (mem_req),
    .mem_kind       (mem_kind),
    .mem_addr       (mem_addr),
    .xfer_go        (xfer_go),
    .xfer_size      (xfer_size),
    .en_o           (en_o),
    .cont_o         (cont_o),
    .status         (status),
    .done_evt       (done_evt),
    .src_done_evt   (src_done_evt),
    .pause_evt      (pause_evt),
    .src_rd_err     (src_rd_err),
    .dst_rd_err     (dst_rd_err)
  );
endmodule

// File: rtl/dcs_chk.sv
module dcs_chk #(
  parameter int ADDR_W  = 49,
  parameter int ALIGN_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_mode,
  input logic              mem_req,
  input logic [1:0]        mem_kind,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_valid,
  input logic              en_o,
  input logic              cont_o,
  input logic [1:0]        status,
  input logic              done_evt,
  input logic              src_done_evt,
  input logic              pause_evt,
  input logic              src_rd_err,
  input logic              dst_rd_err
);
  logic pend;
  always_ff @(posedge clk) begin
    if (rst)            pend <= 1'b0;
    else if (mem_req)   pend <= 1'b1;
    else if (mem_valid) pend <= 1'b0;
  end

  p_req_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !pend);
  p_aligned_req_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_kind != 2'd2 && !reg_mode)
      |-> (((mem_addr >> ALIGN_W) << ALIGN_W) == mem_addr));
  p_err_status_r1: assert property (@(posedge clk) disable iff (rst)
    (src_rd_err || dst_rd_err) |-> (status == 2'd3 && !en_o));
  p_pause_status_r6: assert property (@(posedge clk) disable iff (rst)
    pause_evt |-> (status == 2'd2 && done_evt));
  p_src_done_r10: assert property (@(posedge clk) disable iff (rst)
    src_done_evt |-> done_evt);
  p_resume_r7: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd2 && cont_o && en_o) |=> (status == 2'd1 && !cont_o));
  p_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd2 && cont_o && !en_o) |=> (status == 2'd0 && !mem_req));
endmodule

bind dma_chan_seq dcs_chk #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_chk (.*);

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;
  localparam int AW = 49;
  localparam int SW = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic cfg_wr = 0, cfg_en = 0, cfg_cont = 0, cfg_from_start = 0, reg_mode = 0;
  logic [AW-1:0] src_start = '0, dst_start = '0;
  logic mem_req, mem_valid, xfer_go, xfer_cmpl;
  logic [1:0] mem_kind, dsc_cmd, status;
  logic [AW-1:0] mem_addr, mem_rdata, src_ptr_o, dst_ptr_o;
  logic [SW-1:0] dsc_size, xfer_size;
  logic dsc_linked, dsc_irq, en_o, cont_o, done_evt, src_done_evt, pause_evt;
  logic src_rd_err, dst_rd_err;

  dma_chan_seq u_dut (.*);

  int checks = 0, failures = 0;

  logic [SW-1:0] d_size [logic [AW-1:0]];
  logic          d_lnk  [logic [AW-1:0]];
  logic [1:0]    d_cmd  [logic [AW-1:0]];
  logic          d_irq  [logic [AW-1:0]];
  logic [AW-1:0] d_nx   [logic [AW-1:0]];

  int exp_k [128];
  logic [AW-1:0] exp_a [128];
  int exp_n = 0, exp_i = 0;
  int e_done = 0, e_sd = 0, e_ps = 0;
  int o_done = 0, o_sd = 0, o_ps = 0, o_serr = 0, o_derr = 0;
  logic [AW-1:0] region = 49'h1_0000_0000;
  logic [AW-1:0] last_src = '0;
  logic [AW-1:0] tail_ptr, tail_next;
  logic tail_lnk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [AW-1:0] new_region();
    region = region + 49'h1000;
    return region;
  endfunction

  task automatic push(input int k, input logic [AW-1:0] a);
    exp_k[exp_n] = k;
    exp_a[exp_n] = a;
    exp_n++;
  endtask

  // Builds a chain of n descriptors and appends the requests it will cause.
  task automatic build_chain(input logic [AW-1:0] start, input int n, input logic [1:0] last_cmd);
    logic [AW-1:0] p, nx;
    p = start;
    for (int i = 0; i < n; i++) begin
      d_lnk[p]  = 1'($urandom % 2);
      d_cmd[p]  = (i == n-1) ? last_cmd : 2'd0;
      d_irq[p]  = 1'($urandom % 2);
      d_size[p] = SW'(1 + $urandom % 4000);
      push(1, p);
      e_done++;
      if (d_irq[p]) e_sd++;
      if (d_cmd[p] == 2'd1) e_ps++;
      if (d_lnk[p]) begin
        nx = new_region();
        d_nx[p + 49'd16] = nx;
      end else begin
        nx = p + 49'd16;
      end
      if (i < n-1) begin
        if (d_lnk[p]) push(2, p + 49'd16);
        p = nx;
      end else begin
        tail_ptr  = p;
        tail_lnk  = d_lnk[p];
        tail_next = nx;
      end
    end
  endtask

  task automatic clear_scn();
    exp_n = 0; exp_i = 0; e_done = 0; e_sd = 0; e_ps = 0;
    o_done = 0; o_sd = 0; o_ps = 0; o_serr = 0; o_derr = 0;
  endtask

  task automatic cfg_write(input logic en, input logic ct, input logic fs);
    @(negedge clk);
    cfg_wr = 1; cfg_en = en; cfg_cont = ct; cfg_from_start = fs;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic wait_status(input logic [1:0] v, input string tag);
    int n;
    n = 0;
    while (status != v && n < 4000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(status == v, tag, "status reached", status, v);
  endtask

  task automatic check_totals(input string tag);
    chk(exp_i == exp_n, tag, "request count", exp_i, exp_n);
    chk(o_done == e_done, "R10", "done events", o_done, e_done);
    chk(o_sd == e_sd, "R10", "source-done events", o_sd, e_sd);
    chk(o_ps == e_ps, "R6", "pause events", o_ps, e_ps);
  endtask

  // Memory responder: checks each request against the expected list.
  initial begin
    int k;
    logic [AW-1:0] a;
    mem_valid = 0; mem_rdata = '0; dsc_size = '0; dsc_linked = 0; dsc_cmd = '0; dsc_irq = 0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        k = int'(mem_kind);
        a = mem_addr;
        if (exp_i < exp_n)
          chk(k == exp_k[exp_i] && a == exp_a[exp_i], "R2/R4",
              "request kind*2^52+addr", longint'(k) * 64'h10_0000_0000_0000 + longint'(a),
              longint'(exp_k[exp_i]) * 64'h10_0000_0000_0000 + longint'(exp_a[exp_i]));
        else
          chk(0, "R11", "unexpected request addr", longint'(a), 0);
        exp_i++;
        if (k == 1) last_src = a;
        repeat (1 + $urandom % 3) @(negedge clk);
        if (k == 1 && d_size.exists(a)) begin
          dsc_size = d_size[a]; dsc_linked = d_lnk[a]; dsc_cmd = d_cmd[a]; dsc_irq = d_irq[a];
        end
        if (k == 2 && d_nx.exists(a)) mem_rdata = d_nx[a];
        mem_valid = 1;
        @(negedge clk);
        mem_valid = 0;
      end
    end
  end

  // Data mover responder (R12).
  initial begin
    xfer_cmpl = 0;
    forever begin
      @(negedge clk);
      if (xfer_go) begin
        chk(d_size.exists(last_src) && xfer_size == d_size[last_src], "R12",
            "xfer_size", xfer_size, d_size.exists(last_src) ? d_size[last_src] : 0);
        repeat (1 + $urandom % 3) @(negedge clk);
        xfer_cmpl = 1;
        @(negedge clk);
        xfer_cmpl = 0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done_evt) o_done++;
      if (src_done_evt) o_sd++;
      if (pause_evt) o_ps++;
      if (src_rd_err) o_serr++;
      if (dst_rd_err) o_derr++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s0, s1, d0, d1, p0;
    logic [AW-1:0] keep_dst;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(status == 2'd0 && !en_o && !cont_o && !mem_req, "R1", "reset status", status, 0);

    // Random linear/linked chains ending in stop.
    for (int t = 0; t < 6; t++) begin
      clear_scn();
      dst_start = new_region();
      src_start = new_region();
      push(0, dst_start);
      build_chain(src_start, 1 + int'($urandom % 6), 2'd2);
      cfg_write(1, 0, 0);
      @(negedge clk);
      chk(status == 2'd1, "R1", "status while enabled", status, 1);
      wait_status(2'd0, "R5");
      check_totals("R4");
      chk(!en_o, "R5", "enable cleared by stop", en_o, 0);
      chk(src_ptr_o == tail_ptr, "R4", "source pointer at last descriptor", src_ptr_o, tail_ptr);
      chk(dst_ptr_o == dst_start, "R2", "destination pointer from start", dst_ptr_o, dst_start);
    end

    // Halt then continue at next descriptor.
    for (int t = 0; t < 2; t++) begin
      clear_scn();
      dst_start = new_region();
      src_start = new_region();
      push(0, dst_start);
      build_chain(src_start, 2 + t, 2'd1);
      cfg_write(1, 0, 0);
      wait_status(2'd2, "R6");
      check_totals("R6");
      chk(en_o, "R6", "enable kept in pause", en_o, 1);
      if (tail_lnk) push(2, tail_ptr + 49'd16);
      build_chain(tail_next, 2, 2'd2);
      cfg_write(1, 1, 0);
      @(negedge clk);
      chk(status == 2'd1 && !cont_o, "R7", "resume status*2+cont", status * 2 + cont_o, 2);
      wait_status(2'd0, "R7");
      check_totals("R7");
    end

    // Halt, continue from start (halts again), then disable while paused.
    clear_scn();
    dst_start = new_region();
    src_start = new_region();
    keep_dst = dst_start;
    s0 = exp_n; d0 = e_done; s1 = e_sd; p0 = e_ps;
    push(0, dst_start);
    build_chain(src_start, 3, 2'd1);
    d1 = exp_n;
    cfg_write(1, 0, 0);
    wait_status(2'd2, "R6");
    for (int i = s0; i < d1; i++) push(exp_k[i], exp_a[i]);
    e_done = e_done + (e_done - d0);
    e_sd = e_sd + (e_sd - s1);
    e_ps = e_ps + (e_ps - p0);
    cfg_write(1, 1, 1);
    @(negedge clk);
    chk(status == 2'd1 && !cont_o, "R7", "restart status*2+cont", status * 2 + cont_o, 2);
    wait_status(2'd2, "R7");
    chk(dst_ptr_o == keep_dst, "R7", "destination pointer reloaded", dst_ptr_o, keep_dst);
    cfg_write(0, 1, 0);
    @(negedge clk);
    chk(status == 2'd0, "R8", "disabled from pause", status, 0);
    repeat (6) @(negedge clk);
    check_totals("R8");

    // Misaligned destination start, then recovery.
    clear_scn();
    dst_start = new_region() + 49'd4;
    src_start = new_region();
    cfg_write(1, 0, 0);
    repeat (5) @(negedge clk);
    chk(status == 2'd3, "R1", "error status", status, 3);
    chk(o_derr == 1 && o_serr == 0, "R3", "destination error pulses", o_derr, 1);
    chk(!en_o && exp_i == 0, "R3", "no request and enable cleared", exp_i + en_o, 0);
    dst_start = new_region();
    push(0, dst_start);
    build_chain(src_start, 2, 2'd2);
    cfg_write(1, 0, 0);
    @(negedge clk);
    chk(status == 2'd1, "R9", "error cleared by enable", status, 1);
    wait_status(2'd0, "R9");
    check_totals("R9");

    // Linked pointer to a misaligned source descriptor.
    clear_scn();
    dst_start = new_region();
    src_start = new_region();
    d_lnk[src_start] = 1; d_cmd[src_start] = 0; d_irq[src_start] = 1; d_size[src_start] = 30'd64;
    d_nx[src_start + 49'd16] = new_region() + 49'd8;
    push(0, dst_start); push(1, src_start); push(2, src_start + 49'd16);
    e_done = 1; e_sd = 1;
    cfg_write(1, 0, 0);
    wait_status(2'd3, "R3");
    check_totals("R3");
    chk(o_serr == 1 && o_derr == 0, "R3", "source error pulses", o_serr, 1);
    chk(!en_o, "R3", "enable cleared on source error", en_o, 0);

    // Register mode: no alignment check, single descriptor then disable.
    clear_scn();
    reg_mode = 1;
    dst_start = new_region() + 49'd4;
    src_start = new_region() + 49'd8;
    d_lnk[src_start] = 0; d_cmd[src_start] = 2'd1; d_irq[src_start] = 0; d_size[src_start] = 30'd9;
    push(0, dst_start); push(1, src_start);
    e_done = 1;
    cfg_write(1, 0, 0);
    @(negedge clk);
    chk(status == 2'd1, "R3", "register mode ignores alignment", status, 1);
    wait_status(2'd0, "R5");
    chk(!en_o, "R5", "register mode clears enable", en_o, 0);
    chk(exp_i == exp_n && o_done == 1 && o_ps == 0, "R5", "single run no pause",
        o_done + o_ps, 1);
    reg_mode = 0;

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule